// File: doc/BRIEF.md
# CAN Error Status Encoder with Interrupts

This block sits beside a CAN protocol engine. It watches the engine's transmit and receive error counters and turns each one into a two-bit bus status code: OK, warning, error-passive or bus-off. The codes are registered. On any clock edge where either code changes, a sticky status-change flag is set. The block also keeps a sticky data-overrun flag and a sticky receive-full flag. Each of these three flags is ANDed with an enable bit to drive a level interrupt output.

Software reaches the block through a small synchronous register port with two addresses. Address 0 is the flag/status register: its flags are cleared by writing 1 to them, and its status fields are read-only. Address 1 is the enable register. Two inputs, an initialization request and an initialization acknowledge, guard the enable register. While both are high, the three interrupt enables are held at zero. The write port accepts new enable values only while both are low.

A bus-off transmitter also shows bus-off in the receiver field. When the transmitter leaves bus-off, the receiver field drops straight to OK and stays there until the receive counter itself has fallen back into the OK band.

Top module: `can_err_stat_enc`

## Requirements
- R1: Flag register bits 3:2 give the transmit code one clock after the counter is applied: 00 for counts 0..96, 01 for 97..127, 10 for 128..255, 11 for counts above 255.
- R2: Flag register bits 5:4 give the receive code from the receive counter, with the same timing: 00 for 0..96, 01 for 97..127, 10 for 128 and above.
- R3: While the transmit code is 11 (bus-off), the receive code also reads 11, whatever the receive counter holds.
- R4: When the transmit code leaves 11, the receive code becomes 00 in that same cycle. It stays 00 until the receive counter's own code is 00, and after that it follows the receive counter again.
- R5: Flag register bit 7 (status change) is set on every edge where the transmit code or the receive code changes. It stays set until software clears it by writing 1 to bit 7.
- R6: Flag register bit 1 (overrun) is set by a one-cycle pulse on `ovr_evt`, and bit 0 (receive full) is set by a pulse on `rx_load`. Each is cleared by writing 1 to it. If a set and a clear of the same flag arrive in the same cycle, the set wins.
- R7: Writing 0 to a flag bit leaves that flag unchanged. Writes to flag register bits 6:2 have no effect.
- R8: The enable register at address 1 has this layout: bit 7 status-change enable, bits 5:4 receive-status select, bits 3:2 transmit-status select, bit 1 overrun enable, bit 0 receive-full enable. Bit 6 reads 0. A write takes effect only while `init_req` and `init_ack` are both low. While exactly one of them is high, a write is ignored.
- R9: While `init_req` and `init_ack` are both high, enable bits 7, 1 and 0 are forced to 0 and writes are ignored. The select fields keep their values.
- R10: `irq_stat`, `irq_err` and `irq_rx` are levels. Each one equals its flag (bit 7, 1 or 0) ANDed with the matching enable bit.
- R11: After reset, both registers read 0x00 and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_cnt | input | TX_CNT_W | Transmit error counter from the protocol engine |
| rx_err_cnt | input | RX_CNT_W | Receive error counter from the protocol engine |
| ovr_evt | input | 1 | One-cycle pulse: data overrun occurred |
| rx_load | input | 1 | One-cycle pulse: a received message was moved to the foreground buffer |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 flags/status, 1 enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_stat | output | 1 | Status-change interrupt level |
| irq_err | output | 1 | Overrun (error) interrupt level |
| irq_rx | output | 1 | Receive-full interrupt level |

## Verification
Every counter boundary is tested: 96/97, 127/128 and 255/256. An encoder with an off-by-one comparison would report the wrong band at exactly one of these values. The bench drives the transmitter into bus-off and back out while the receive counter is still high. A design that simply re-encoded the receive counter would show error-passive where OK is required, and a design with no hold would drop the receiver field to OK for one cycle and then bounce back. The bench also raises an overrun in the same cycle as its clear, which catches a clear-wins priority. It writes enables while only one of the two initialization signals is high, and then while both are high, which catches an enable register that either accepts the write or forgets its select fields.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

   typedef enum logic [1:0] {
      BUS_OK      = 2'b00,
      BUS_WARN    = 2'b01,
      BUS_PASSIVE = 2'b10,
      BUS_OFF     = 2'b11
   } bus_state_e;

   localparam int REG_W   = 8;
   localparam int N_FLAGS = 3;

   localparam int FL_RXF = 0;
   localparam int FL_OVR = 1;
   localparam int FL_CHG = 2;

   localparam int BIT_RXF = 0;
   localparam int BIT_OVR = 1;
   localparam int BIT_CHG = 7;

endpackage

// File: rtl/err_level_enc.sv
module err_level_enc
   import can_stat_pkg::*;
#(
   parameter int CNT_W         = 9,
   parameter int WARN_LIMIT    = 96,
   parameter int PASSIVE_LIMIT = 127,
   parameter int BUSOFF_LIMIT  = 255,
   parameter bit HAS_BUSOFF    = 1'b1
) (
   input  logic [CNT_W-1:0] cnt,
   output bus_state_e       code
);

   localparam logic [CNT_W-1:0] WARN_C    = CNT_W'(WARN_LIMIT);
   localparam logic [CNT_W-1:0] PASSIVE_C = CNT_W'(PASSIVE_LIMIT);

   if (WARN_LIMIT >= PASSIVE_LIMIT) begin : g_bad_order
      $error("err_level_enc: WARN_LIMIT must be below PASSIVE_LIMIT");
   end
   if (PASSIVE_LIMIT >= (2 ** CNT_W) - 1) begin : g_bad_width
      $error("err_level_enc: counter too narrow for PASSIVE_LIMIT");
   end

   if (HAS_BUSOFF) begin : g_with_off
      localparam logic [CNT_W-1:0] OFF_C = CNT_W'(BUSOFF_LIMIT);
      if (BUSOFF_LIMIT >= (2 ** CNT_W) - 1) begin : g_off_unreachable
         $error("err_level_enc: counter too narrow to exceed BUSOFF_LIMIT");
      end
      always_comb begin
         if (cnt > OFF_C)          code = BUS_OFF;
         else if (cnt > PASSIVE_C) code = BUS_PASSIVE;
         else if (cnt > WARN_C)    code = BUS_WARN;
         else                      code = BUS_OK;
      end
   end else begin : g_no_off
      always_comb begin
         if (cnt > PASSIVE_C)      code = BUS_PASSIVE;
         else if (cnt > WARN_C)    code = BUS_WARN;
         else                      code = BUS_OK;
      end
   end

endmodule

// File: rtl/status_track.sv
module status_track
   import can_stat_pkg::*;
#(
   parameter bit MIRROR_BUSOFF = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  bus_state_e tx_raw,
   input  bus_state_e rx_raw,
   output bus_state_e tx_code,
   output bus_state_e rx_code,
   output logic       chg_evt
);

   bus_state_e tx_q;
   bus_state_e rx_q;
   bus_state_e rx_next;

   if (MIRROR_BUSOFF) begin : g_mirror
      logic hold_q;
      logic leaving;

      assign leaving = (tx_q == BUS_OFF) && (tx_raw != BUS_OFF);

      always_comb begin
         if (tx_raw == BUS_OFF)       rx_next = BUS_OFF;
         else if (leaving || hold_q)  rx_next = BUS_OK;
         else                         rx_next = rx_raw;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             hold_q <= 1'b0;
         else if (tx_raw == BUS_OFF)             hold_q <= 1'b0;
         else if (leaving)                       hold_q <= (rx_raw != BUS_OK);
         else if (hold_q && (rx_raw == BUS_OK))  hold_q <= 1'b0;
      end

      // R3
      busoff_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_code == BUS_OFF) |-> (rx_code == BUS_OFF));

      // R4
      busoff_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (($past(tx_code) == BUS_OFF) && (tx_code != BUS_OFF)) |-> (rx_code == BUS_OK));
   end else begin : g_plain
      always_comb rx_next = rx_raw;
   end

   assign chg_evt = (tx_raw != tx_q) || (rx_next != rx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= BUS_OK;
         rx_q <= BUS_OK;
      end else begin
         tx_q <= tx_raw;
         rx_q <= rx_next;
      end
   end

   assign tx_code = tx_q;
   assign rx_code = rx_q;

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);

   if (N < 1) begin : g_bad_n
      $error("flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (set[i]) f_q <= 1'b1;
         else if (clr[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);

      // R5
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);

      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr[i] && !set[i]) |=> $stable(flags[i]));
   end

endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
   parameter int N_IE  = 3,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [N_IE-1:0]  wdata_ie,
   input  logic [SEL_W-1:0] wdata_sel,
   input  logic             init_req,
   input  logic             init_ack,
   output logic [N_IE-1:0]  ie,
   output logic [SEL_W-1:0] sel
);

   logic in_init;
   logic wr_ok;

   assign in_init = init_req && init_ack;
   assign wr_ok   = wr && !init_req && !init_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ie <= '0;
      else if (in_init) ie <= '0;
      else if (wr_ok)   ie <= wdata_ie;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel <= '0;
      else if (wr_ok) sel <= wdata_sel;
   end

   // R9
   init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req && init_ack) |=> (ie == '0));

   // R9
   sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req || init_ack) |=> $stable(sel));

   // R8
   half_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req != init_ack) |=> $stable(ie));

endmodule

// File: rtl/can_err_stat_enc.sv
module can_err_stat_enc
   import can_stat_pkg::*;
#(
   parameter int TX_CNT_W      = 9,
   parameter int RX_CNT_W      = 8,
   parameter int WARN_LIMIT    = 96,
   parameter int PASSIVE_LIMIT = 127,
   parameter int BUSOFF_LIMIT  = 255,
   parameter bit MIRROR_BUSOFF = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TX_CNT_W-1:0] tx_err_cnt,
   input  logic [RX_CNT_W-1:0] rx_err_cnt,
   input  logic                ovr_evt,
   input  logic                rx_load,
   input  logic                init_req,
   input  logic                init_ack,
   input  logic                reg_wr,
   input  logic                reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   output logic                irq_stat,
   output logic                irq_err,
   output logic                irq_rx
);

   localparam int SEL_W = 4;
   localparam logic [TX_CNT_W-1:0] OFF_C = TX_CNT_W'(BUSOFF_LIMIT);

   if (TX_CNT_W < 9) begin : g_tx_narrow
      $error("can_err_stat_enc: TX_CNT_W must be at least 9 to express bus-off");
   end
   if (REG_W != 8) begin : g_reg_w
      $error("can_err_stat_enc: register layout assumes 8-bit registers");
   end

   bus_state_e tx_raw, rx_raw, tx_code, rx_code;
   logic       chg_evt;
   logic [N_FLAGS-1:0] fl_set, fl_clr, flags;
   logic [N_FLAGS-1:0] ie;
   logic [SEL_W-1:0]   sel;
   logic wr_flags, wr_en;
   logic wdata_unused;

   err_level_enc #(
      .CNT_W(TX_CNT_W), .WARN_LIMIT(WARN_LIMIT), .PASSIVE_LIMIT(PASSIVE_LIMIT),
      .BUSOFF_LIMIT(BUSOFF_LIMIT), .HAS_BUSOFF(1'b1)
   ) i_tx_enc (
      .cnt(tx_err_cnt), .code(tx_raw)
   );

   err_level_enc #(
      .CNT_W(RX_CNT_W), .WARN_LIMIT(WARN_LIMIT), .PASSIVE_LIMIT(PASSIVE_LIMIT),
      .BUSOFF_LIMIT(BUSOFF_LIMIT), .HAS_BUSOFF(1'b0)
   ) i_rx_enc (
      .cnt(rx_err_cnt), .code(rx_raw)
   );

   status_track #(
      .MIRROR_BUSOFF(MIRROR_BUSOFF)
   ) i_track (
      .clk(clk), .rst_n(rst_n), .tx_raw(tx_raw), .rx_raw(rx_raw),
      .tx_code(tx_code), .rx_code(rx_code), .chg_evt(chg_evt)
   );

   assign wr_flags = reg_wr && !reg_addr;
   assign wr_en    = reg_wr &&  reg_addr;

   always_comb begin
      fl_set         = '0;
      fl_set[FL_RXF] = rx_load;
      fl_set[FL_OVR] = ovr_evt;
      fl_set[FL_CHG] = chg_evt;
      fl_clr         = '0;
      fl_clr[FL_RXF] = wr_flags && reg_wdata[BIT_RXF];
      fl_clr[FL_OVR] = wr_flags && reg_wdata[BIT_OVR];
      fl_clr[FL_CHG] = wr_flags && reg_wdata[BIT_CHG];
   end

   flag_bank #(.N(N_FLAGS)) i_flags (
      .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(fl_clr), .flags(flags)
   );

   irq_en_reg #(.N_IE(N_FLAGS), .SEL_W(SEL_W)) i_en (
      .clk(clk), .rst_n(rst_n), .wr(wr_en),
      .wdata_ie({reg_wdata[BIT_CHG], reg_wdata[BIT_OVR], reg_wdata[BIT_RXF]}),
      .wdata_sel(reg_wdata[5:2]),
      .init_req(init_req), .init_ack(init_ack), .ie(ie), .sel(sel)
   );

   assign wdata_unused = reg_wdata[6];

   always_comb begin
      if (reg_addr)
         reg_rdata = {ie[FL_CHG], 1'b0, sel, ie[FL_OVR], ie[FL_RXF]};
      else
         reg_rdata = {flags[FL_CHG], 1'b0, rx_code, tx_code, flags[FL_OVR], flags[FL_RXF]};
   end

   assign irq_stat = flags[FL_CHG] && ie[FL_CHG];
   assign irq_err  = flags[FL_OVR] && ie[FL_OVR];
   assign irq_rx   = flags[FL_RXF] && ie[FL_RXF];

   // R1
   tx_busoff_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_code == BUS_OFF) |-> ($past(tx_err_cnt) > OFF_C));

   // R5
   chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FL_CHG]) |-> ((tx_code != $past(tx_code)) || (rx_code != $past(rx_code))));

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == '0) |-> (!irq_stat && !irq_err && !irq_rx));

endmodule

// File: tb/test_can_err_stat_enc.sv
`timescale 1ns/1ps
module test_can_err_stat_enc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] tx_err_cnt = '0;
   logic [7:0] rx_err_cnt = '0;
   logic       ovr_evt = 1'b0;
   logic       rx_load = 1'b0;
   logic       init_req = 1'b0;
   logic       init_ack = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_stat, irq_err, irq_rx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   can_err_stat_enc i_can_err_stat_enc (
      .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
      .ovr_evt(ovr_evt), .rx_load(rx_load), .init_req(init_req), .init_ack(init_ack),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_stat(irq_stat), .irq_err(irq_err), .irq_rx(irq_rx)
   );

   function automatic logic [1:0] ref_code(int cnt, bit with_off);
      if (with_off && cnt > 255) return 2'b11;
      if (cnt > 127) return 2'b10;
      if (cnt > 96)  return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_cnt(input int tx, input int rx);
      @(negedge clk);
      tx_err_cnt = 9'(tx);
      rx_err_cnt = 8'(rx);
      @(negedge clk);
   endtask

   task automatic pulse_ovr();
      @(negedge clk); ovr_evt = 1'b1;
      @(negedge clk); ovr_evt = 1'b0;
   endtask

   task automatic pulse_rxl();
      @(negedge clk); rx_load = 1'b1;
      @(negedge clk); rx_load = 1'b0;
   endtask

   function automatic logic [7:0] irqs();
      return {5'b0, irq_stat, irq_err, irq_rx};
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, d); check("R11 flag reg", d, 8'h00);
      rd(1'b1, d); check("R11 enable reg", d, 8'h00);
      check("R11 irqs", irqs(), 8'h00);
   endtask

   task automatic t_tx_codes();
      logic [7:0] d;
      int vals[6] = '{0, 96, 97, 127, 128, 255};
      foreach (vals[k]) begin
         set_cnt(vals[k], 0);
         rd(1'b0, d);
         check($sformatf("R1 tx code at %0d", vals[k]), {6'b0, d[3:2]}, {6'b0, ref_code(vals[k], 1'b1)});
      end
   endtask

   task automatic t_rx_codes();
      logic [7:0] d;
      int vals[6] = '{96, 97, 127, 128, 255, 0};
      foreach (vals[k]) begin
         set_cnt(0, vals[k]);
         rd(1'b0, d);
         check($sformatf("R2 rx code at %0d", vals[k]), {4'b0, d[5:2]}, {4'b0, ref_code(vals[k], 1'b0), 2'b00});
      end
   endtask

   task automatic t_busoff();
      logic [7:0] d;
      set_cnt(256, 50);  rd(1'b0, d);
      check("R1 tx bus-off at 256", {6'b0, d[3:2]}, 8'h03);
      check("R3 rx mirrors bus-off", {6'b0, d[5:4]}, 8'h03);
      set_cnt(300, 200); rd(1'b0, d);
      check("R3 rx bus-off with high rx count", {4'b0, d[5:2]}, 8'h0F);
      set_cnt(0, 130);   rd(1'b0, d);
      check("R4 rx to OK on bus-off exit", {4'b0, d[5:2]}, 8'h00);
      set_cnt(0, 140);   rd(1'b0, d);
      check("R4 rx held OK", {6'b0, d[5:4]}, 8'h00);
      set_cnt(0, 20);    rd(1'b0, d);
      check("R4 rx OK band", {6'b0, d[5:4]}, 8'h00);
      set_cnt(0, 100);   rd(1'b0, d);
      check("R4 rx follows again", {6'b0, d[5:4]}, 8'h01);
   endtask

   task automatic t_chg();
      logic [7:0] d;
      set_cnt(0, 0);
      wr(1'b0, 8'h80); rd(1'b0, d);
      check("R5 change flag cleared", {7'b0, d[7]}, 8'h00);
      set_cnt(100, 0); rd(1'b0, d);
      check("R5 change flag on tx change", {7'b0, d[7]}, 8'h01);
      wr(1'b0, 8'h7F); rd(1'b0, d);
      check("R7 zero write keeps flag, status read-only", {d[7], 3'b0, d[5:2]}, 8'h81);
      wr(1'b0, 8'h80);
      @(negedge clk); @(negedge clk); rd(1'b0, d);
      check("R5 no set without change", {7'b0, d[7]}, 8'h00);
      set_cnt(100, 110); rd(1'b0, d);
      check("R5 change flag on rx change", {7'b0, d[7]}, 8'h01);
      wr(1'b0, 8'h80);
   endtask

   task automatic t_flags();
      logic [7:0] d;
      pulse_ovr(); rd(1'b0, d);
      check("R6 overrun set", {6'b0, d[1:0]}, 8'h02);
      pulse_rxl(); rd(1'b0, d);
      check("R6 rx full set", {6'b0, d[1:0]}, 8'h03);
      wr(1'b0, 8'h02); rd(1'b0, d);
      check("R6 overrun w1c", {6'b0, d[1:0]}, 8'h01);
      wr(1'b0, 8'h01); rd(1'b0, d);
      check("R6 rx full w1c", {6'b0, d[1:0]}, 8'h00);
      @(negedge clk);
      ovr_evt = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h02; reg_wr = 1'b1;
      @(negedge clk);
      ovr_evt = 1'b0; reg_wr = 1'b0;
      rd(1'b0, d);
      check("R6 set wins over clear", {6'b0, d[1:0]}, 8'h02);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(1'b1, 8'hBF); rd(1'b1, d);
      check("R8 enable write", d, 8'hBF);
      pulse_rxl();
      set_cnt(0, 110);
      check("R10 all irqs", irqs(), 8'h07);
      wr(1'b1, 8'h3C);
      check("R10 irqs masked", irqs(), 8'h00);
      rd(1'b0, d);
      check("R10 flags kept when masked", {d[7], 5'b0, d[1:0]}, 8'h83);
      wr(1'b1, 8'h81);
      check("R10 partial enables", irqs(), 8'h05);
   endtask

   task automatic t_init();
      logic [7:0] d;
      wr(1'b1, 8'hBF);
      @(negedge clk); init_req = 1'b1;
      wr(1'b1, 8'h00); rd(1'b1, d);
      check("R8 write blocked with request only", d, 8'hBF);
      @(negedge clk); init_ack = 1'b1;
      @(negedge clk); rd(1'b1, d);
      check("R9 enables forced low, selects kept", d, 8'h3C);
      check("R9 irqs low in init", irqs(), 8'h00);
      wr(1'b1, 8'hFF); rd(1'b1, d);
      check("R9 write ignored in init", d, 8'h3C);
      @(negedge clk); init_req = 1'b0; init_ack = 1'b0;
      @(negedge clk); rd(1'b1, d);
      check("R9 value after leaving init", d, 8'h3C);
      wr(1'b1, 8'h83); rd(1'b1, d);
      check("R8 write after init", d, 8'h83);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_codes();
      t_rx_codes();
      t_busoff();
      t_chg();
      t_flags();
      t_irq();
      t_init();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule